// File: doc/BRIEF.md
# USB Transmit Endpoint Packet Buffer

This block keeps the outgoing packets of one configurable USB IN endpoint in a small local byte RAM. The processor loads bytes one at a time through a write port. It then marks the packet as ready with a strobe. Optionally, the block marks a packet ready by itself once exactly one maximum-sized packet has been loaded. A programmable maximum packet size and a FIFO size input decide whether one or two packets may wait at the same time. Two packets are allowed only when double buffering is enabled and the FIFO holds at least two maximum-sized packets.

On the host side, a simplified serial-engine handshake sees a request flag and the length of the oldest ready packet. It pulls that packet's bytes in load order and then reports success or retry. On success the packet is released, the ready and not-empty flags drop once nothing is left, and a one-cycle transmit interrupt follows. On retry the packet stays queued and its byte stream starts again from the first byte.

Top module: `usb_txep_buf`

## Requirements
- R1: While `rst` is high at a clock edge, all queued and partly loaded data is discarded. After that edge `ep_txrdy`, `ep_fifo_ne`, `sie_req` and `tx_irq` are all 0.
- R2: The number of packets that may be queued is 2 when `cfg_dbl_en` is 1 and `cfg_fifo_sz` >= 2 × `maxp_q`; otherwise it is 1. Byte writes and ready strobes made while the queue is at that limit are ignored.
- R3: With `cfg_dbl_en` at 0, only one packet is queued, even when the packet is much smaller than half the FIFO.
- R4: A `cpu_pkt_rdy` pulse queues the bytes loaded since the last queued packet as one packet of that length, including a length of zero. A byte written in the same cycle is included.
- R5: With `cfg_auto_en` at 1, the write that brings the loaded byte count to exactly `maxp_q` queues the packet in the same cycle. Shorter packets still need `cpu_pkt_rdy`.
- R6: `ep_txrdy` is 1 exactly when the number of queued packets equals the limit of R2. `ep_fifo_ne` is 1 whenever any packet is queued or any byte is partly loaded.
- R7: `sie_req` is 1 while a packet is queued, and `sie_len` gives the oldest packet's length. `sie_rd_data` shows its bytes in load order, and each `sie_rd_en` advances to the next byte.
- R8: `sie_done` with `sie_ok` = 1 releases the oldest packet. `tx_irq` is then 1 for exactly the next cycle, and packets leave in the order they were queued.
- R9: `sie_done` with `sie_ok` = 0 keeps the packet queued with the same length and restarts its byte stream at the first byte.
- R10: A `maxp_we` write loads `maxp_wdata` into `maxp_q` only while `ep_fifo_ne` is 0; otherwise it is ignored.
- R11: `cfg_err` is 1 when `maxp_q` exceeds `cfg_fifo_sz` or `cfg_fifo_sz` exceeds the RAM depth. While it is 1, byte writes and ready strobes are ignored.
- R12: Bytes written after a packet already holds `maxp_q` bytes are ignored, so a queued packet never exceeds `maxp_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_sz | input | ADDR_W+1 | FIFO size in bytes |
| cfg_dbl_en | input | 1 | Double-buffer enable |
| cfg_auto_en | input | 1 | Automatic ready on a full-sized packet |
| maxp_we | input | 1 | Maximum packet size write strobe |
| maxp_wdata | input | ADDR_W+1 | Maximum packet size write value |
| maxp_q | output | ADDR_W+1 | Current maximum packet size |
| cfg_err | output | 1 | Size configuration error |
| cpu_wr_en | input | 1 | Byte write strobe |
| cpu_wr_data | input | DATA_W | Byte to load |
| cpu_pkt_rdy | input | 1 | Manual packet ready strobe |
| ep_txrdy | output | 1 | All allowed packet slots are ready |
| ep_fifo_ne | output | 1 | FIFO holds data |
| sie_req | output | 1 | A packet is waiting for transmission |
| sie_len | output | ADDR_W+1 | Length of the oldest queued packet |
| sie_rd_en | input | 1 | Advance to the next byte |
| sie_rd_data | output | DATA_W | Current byte of the oldest packet |
| sie_done | input | 1 | Transmission attempt finished |
| sie_ok | input | 1 | Attempt result: 1 success, 0 retry |
| tx_irq | output | 1 | One-cycle transmit-complete pulse |

## Verification
The assertions check several rules on every cycle:
- the load counter never passes the maximum packet size;
- nothing is queued beyond the slot limit or while the size configuration is in error;
- a release always produces a single-cycle interrupt;
- the queued count steps down by one on a release;
- a retry returns the read offset to zero without moving the slot;
- the maximum size holds steady while data is present.

Other behaviours depend on what the bench drives, so only its scenarios can show them. These are the byte-exact contents and order of packets, the automatic ready taking exactly a full-sized packet, zero-length and short packets, and writes ignored when the queue is full.

// File: rtl/txep_pkg.sv
package txep_pkg;

  // Number of packets that may wait at once.
  function automatic logic [1:0] slot_limit(logic dbl, int fifo_bytes, int maxp_bytes);
    return (dbl && (fifo_bytes >= 2 * maxp_bytes)) ? 2'd2 : 2'd1;
  endfunction

  // First byte of a packet slot inside the endpoint region.
  function automatic int slot_base(logic slot, int maxp_bytes);
    return slot ? maxp_bytes : 0;
  endfunction

endpackage

// File: rtl/txep_ram.sv
module txep_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txep_loader.sv
module txep_loader
  import txep_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rdy_set,
  input  logic              auto_en,
  input  logic              can_load,
  input  logic              two_slots,
  input  logic [PW-1:0]     maxp,
  output logic              wr_ok,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              commit,
  output logic [PW-1:0]     commit_len,
  output logic              commit_slot,
  output logic              partial
);
  logic [PW-1:0] ld_cnt;
  logic [PW-1:0] new_cnt;
  logic          wr_slot;
  logic          auto_hit;

  assign wr_ok       = wr_en && can_load && (ld_cnt < maxp);
  assign new_cnt     = ld_cnt + {{(PW-1){1'b0}}, wr_ok};
  assign auto_hit    = auto_en && wr_ok && (new_cnt == maxp);
  assign commit      = can_load && (rdy_set || auto_hit);
  assign commit_len  = new_cnt;
  assign commit_slot = wr_slot;
  assign partial     = (ld_cnt != '0);
  assign wr_addr     = ADDR_W'(slot_base(wr_slot, int'(maxp)) + int'(ld_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt  <= '0;
      wr_slot <= 1'b0;
    end else if (commit) begin
      ld_cnt  <= '0;
      wr_slot <= two_slots ? ~wr_slot : 1'b0;
    end else begin
      ld_cnt  <= new_cnt;
    end
  end

  p_load_bound_r12: assert property (@(posedge clk) disable iff (rst)
    ld_cnt <= maxp);

  p_commit_clears_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (ld_cnt == '0));
endmodule

// File: rtl/txep_reader.sv
module txep_reader
  import txep_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              done,
  input  logic              ok,
  input  logic              avail,
  input  logic              two_slots,
  input  logic [PW-1:0]     maxp,
  input  logic [PW-1:0]     cur_len,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_slot,
  output logic              pop,
  output logic              rewind
);
  logic [PW-1:0] rd_off;
  logic          adv;

  assign adv     = rd_en && avail && (rd_off < cur_len);
  assign pop     = done && ok && avail;
  assign rewind  = done && !ok && avail;
  assign rd_addr = ADDR_W'(slot_base(rd_slot, int'(maxp)) + int'(rd_off));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_off  <= '0;
      rd_slot <= 1'b0;
    end else if (pop) begin
      rd_off  <= '0;
      rd_slot <= two_slots ? ~rd_slot : 1'b0;
    end else if (rewind) begin
      rd_off  <= '0;
    end else if (adv) begin
      rd_off  <= rd_off + 1'b1;
    end
  end

  p_retry_restart_r9: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rd_off == '0) && $stable(rd_slot));

  p_read_bound_r7: assert property (@(posedge clk) disable iff (rst)
    avail |-> (rd_off <= cur_len));
endmodule

// File: rtl/usb_txep_buf.sv
module usb_txep_buf
  import txep_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int MAXP_RST = 8,
  localparam int PW      = ADDR_W + 1,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     cfg_fifo_sz,
  input  logic              cfg_dbl_en,
  input  logic              cfg_auto_en,
  input  logic              maxp_we,
  input  logic [PW-1:0]     maxp_wdata,
  output logic [PW-1:0]     maxp_q,
  output logic              cfg_err,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_pkt_rdy,
  output logic              ep_txrdy,
  output logic              ep_fifo_ne,
  output logic              sie_req,
  output logic [PW-1:0]     sie_len,
  input  logic              sie_rd_en,
  output logic [DATA_W-1:0] sie_rd_data,
  input  logic              sie_done,
  input  logic              sie_ok,
  output logic              tx_irq
);
  logic [1:0]        pkt_cnt;
  logic [1:0]        cap;
  logic              two_slots;
  logic              can_load;
  logic [PW-1:0]     len_q [2];
  logic              wr_ok, commit, commit_slot, partial;
  logic [PW-1:0]     commit_len;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              rd_slot, pop, rewind;

  assign cap       = slot_limit(cfg_dbl_en, int'(cfg_fifo_sz), int'(maxp_q));
  assign two_slots = (cap == 2'd2);
  assign cfg_err   = (maxp_q > cfg_fifo_sz) || (int'(cfg_fifo_sz) > DEPTH);
  assign can_load  = !cfg_err && (pkt_cnt < cap);

  assign ep_txrdy   = (pkt_cnt == cap);
  assign ep_fifo_ne = (pkt_cnt != 2'd0) || partial;
  assign sie_req    = (pkt_cnt != 2'd0);
  assign sie_len    = len_q[rd_slot];

  txep_loader #(.ADDR_W(ADDR_W)) u_loader (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cpu_wr_en),
    .rdy_set    (cpu_pkt_rdy),
    .auto_en    (cfg_auto_en),
    .can_load   (can_load),
    .two_slots  (two_slots),
    .maxp       (maxp_q),
    .wr_ok      (wr_ok),
    .wr_addr    (wr_addr),
    .commit     (commit),
    .commit_len (commit_len),
    .commit_slot(commit_slot),
    .partial    (partial)
  );

  txep_reader #(.ADDR_W(ADDR_W)) u_reader (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (sie_rd_en),
    .done     (sie_done),
    .ok       (sie_ok),
    .avail    (sie_req),
    .two_slots(two_slots),
    .maxp     (maxp_q),
    .cur_len  (sie_len),
    .rd_addr  (rd_addr),
    .rd_slot  (rd_slot),
    .pop      (pop),
    .rewind   (rewind)
  );

  txep_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(wr_addr),
    .wdata(cpu_wr_data),
    .raddr(rd_addr),
    .rdata(sie_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_cnt  <= 2'd0;
      tx_irq   <= 1'b0;
      maxp_q   <= PW'(MAXP_RST);
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      pkt_cnt <= pkt_cnt + {1'b0, commit} - {1'b0, pop};
      tx_irq  <= pop;
      if (maxp_we && !ep_fifo_ne) maxp_q <= maxp_wdata;
      if (commit) len_q[commit_slot] <= commit_len;
    end
  end

  p_slot_limit_r2: assert property (@(posedge clk) disable iff (rst)
    commit |-> (pkt_cnt < cap));

  p_err_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!commit && !wr_ok));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    pop |=> tx_irq);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !pop) |=> !tx_irq);

  p_release_step_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && !commit) |=> (pkt_cnt == $past(pkt_cnt) - 2'd1));

  p_maxp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ep_fifo_ne |=> $stable(maxp_q));
endmodule

// File: tb/usb_txep_buf_bench.sv
module usb_txep_buf_bench;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int PW = AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] cfg_fifo_sz = PW'(16);
  logic          cfg_dbl_en = 1'b0, cfg_auto_en = 1'b0;
  logic          maxp_we = 1'b0;
  logic [PW-1:0] maxp_wdata = '0;
  logic [PW-1:0] maxp_q;
  logic          cfg_err;
  logic          cpu_wr_en = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic          cpu_pkt_rdy = 1'b0;
  logic          ep_txrdy, ep_fifo_ne, sie_req, tx_irq;
  logic [PW-1:0] sie_len;
  logic          sie_rd_en = 1'b0, sie_done = 1'b0, sie_ok = 1'b0;
  logic [DW-1:0] sie_rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  usb_txep_buf u_usb_txep_buf (
    .clk(clk), .rst(rst), .cfg_fifo_sz(cfg_fifo_sz), .cfg_dbl_en(cfg_dbl_en),
    .cfg_auto_en(cfg_auto_en), .maxp_we(maxp_we), .maxp_wdata(maxp_wdata),
    .maxp_q(maxp_q), .cfg_err(cfg_err), .cpu_wr_en(cpu_wr_en),
    .cpu_wr_data(cpu_wr_data), .cpu_pkt_rdy(cpu_pkt_rdy), .ep_txrdy(ep_txrdy),
    .ep_fifo_ne(ep_fifo_ne), .sie_req(sie_req), .sie_len(sie_len),
    .sie_rd_en(sie_rd_en), .sie_rd_data(sie_rd_data), .sie_done(sie_done),
    .sie_ok(sie_ok), .tx_irq(tx_irq)
  );

  function automatic int pat(int p, int i, int m);
    return (p * 37 + i * 5 + m * 11) & 255;
  endfunction

  function automatic int plen(int p, int m);
    return (p == 0) ? m : ((m - p) > 0 ? m - p : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    chk("R1 txrdy", int'(ep_txrdy), 0);
    chk("R1 fifo_ne", int'(ep_fifo_ne), 0);
    chk("R1 sie_req", int'(sie_req), 0);
    chk("R1 tx_irq", int'(tx_irq), 0);
  endtask

  task automatic set_maxp(int m);
    maxp_we = 1'b1;
    maxp_wdata = PW'(m);
    step();
    maxp_we = 1'b0;
  endtask

  task automatic put_byte(int v);
    cpu_wr_en = 1'b1;
    cpu_wr_data = DW'(v);
    step();
    cpu_wr_en = 1'b0;
  endtask

  task automatic strobe();
    cpu_pkt_rdy = 1'b1;
    step();
    cpu_pkt_rdy = 1'b0;
  endtask

  task automatic finish_sie(logic good);
    sie_done = 1'b1;
    sie_ok = good;
    step();
    sie_done = 1'b0;
    sie_ok = 1'b0;
  endtask

  task automatic read_byte(string req, int exp);
    chk(req, int'(sie_rd_data), exp);
    sie_rd_en = 1'b1;
    step();
    sie_rd_en = 1'b0;
  endtask

  task automatic run_cfg(int m, int f, logic d, logic a);
    int cap;
    int len;
    cfg_fifo_sz = PW'(f);
    cfg_dbl_en = d;
    cfg_auto_en = a;
    do_reset();
    set_maxp(m);
    chk("R10 maxp load", int'(maxp_q), m);
    cap = (d && f >= 2 * m) ? 2 : 1;
    for (int p = 0; p < 3; p++) begin
      len = plen(p, m);
      for (int i = 0; i < len; i++) put_byte(pat(p, i, m));
      if (!(a && len == m)) strobe();
      // R3: with double buffering off cap stays 1
      chk("R6 txrdy", int'(ep_txrdy), ((p + 1 >= cap) ? 1 : 0));
      chk("R6 fifo_ne", int'(ep_fifo_ne), 1);
    end
    set_maxp(m + 1);
    chk("R10 maxp held", int'(maxp_q), m);
    for (int q = 0; q < cap; q++) begin
      len = plen(q, m);
      chk("R7 sie_req", int'(sie_req), 1);
      chk("R4 R5 sie_len", int'(sie_len), len);
      if (q == 0) begin
        read_byte("R7 data", pat(q, 0, m));
        finish_sie(1'b0);
        chk("R9 len kept", int'(sie_len), len);
        chk("R9 restart", int'(sie_rd_data), pat(q, 0, m));
        chk("R9 no irq", int'(tx_irq), 0);
      end
      for (int i = 0; i < len; i++) read_byte("R7 data", pat(q, i, m));
      finish_sie(1'b1);
      chk("R8 irq", int'(tx_irq), 1);
      step();
      chk("R8 irq pulse", int'(tx_irq), 0);
    end
    chk("R2 queue drained", int'(sie_req), 0);
    chk("R6 fifo_ne clear", int'(ep_fifo_ne), 0);
    chk("R6 txrdy clear", int'(ep_txrdy), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int m = 1; m <= 8; m++)
      for (int fi = 0; fi < 2; fi++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 2; a++)
            run_cfg(m, (fi == 0) ? 8 : 16, d[0], a[0]);

    // R12: bytes beyond the maximum size are dropped
    cfg_fifo_sz = PW'(16);
    cfg_dbl_en = 1'b0;
    cfg_auto_en = 1'b0;
    do_reset();
    set_maxp(4);
    for (int i = 0; i < 6; i++) put_byte(pat(5, i, 4));
    strobe();
    chk("R12 len capped", int'(sie_len), 4);
    for (int i = 0; i < 4; i++) read_byte("R12 data", pat(5, i, 4));
    finish_sie(1'b1);

    // R11: size error blocks loading
    do_reset();
    cfg_fifo_sz = PW'(4);
    set_maxp(8);
    chk("R11 err set", int'(cfg_err), 1);
    for (int i = 0; i < 3; i++) put_byte(i);
    strobe();
    chk("R11 no data", int'(ep_fifo_ne), 0);
    chk("R11 no packet", int'(sie_req), 0);
    cfg_fifo_sz = PW'(16);
    step();
    chk("R11 err clear", int'(cfg_err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule